// File: doc/BRIEF.md
# Strobed Serial Control Register Port

This block is a write-only, three-wire serial port through which a host microcontroller loads 16-bit control words into a bank of four on-chip control registers. The host holds an active-low frame-enable line low, puts each data bit on the data line and raises the strobe line to clock it in, most significant bit first. After sixteen bits the host releases frame-enable, and the word takes effect only once four further strobe pulses have been seen. Until then the registers keep their old values.

The strobe, frame-enable and data pins are asynchronous to the chip clock. Each passes through a two-flop synchroniser. The port then looks at them only on cycles where a one-cycle frame tick is high, which stands for the 8 kHz frame rate. A strobe pulse that begins and ends between two ticks is never seen, and a strobe held high across many ticks counts as one edge. Bits 2 and 1 of the loaded word pick the destination register. A word whose bit 0 is 1 is thrown away. The registers drive the rest of the chip directly, and the fields of register 2 and the microphone-enable bit of register 0 are also brought out one by one.

Top module: `serctl_port`

## Requirements
- R1: After reset the registers read 0x8000, 0x0002, 0x0004 and 0x0006 for index 0 to 3. The register value always includes its own index in bits 2:1. micEnable is 1, every register-2 field is 0, and wrPulse is 0.
- R2: While serEnableN is low, each rising strobe edge seen at a tick shifts one data bit in, most significant bit first. The first bit received becomes bit 15 of the word.
- R3: A word is written only at the fourth rising strobe edge after serEnableN has returned high. After three trailing edges, no register has changed.
- R4: The written register is the one whose index equals word bits 2:1. The other three registers keep their values.
- R5: A complete word with bit 0 equal to 1 changes no register and raises no wrPulse.
- R6: If serEnableN rises after fewer than sixteen bits, the partial word is dropped, and trailing strobes then write nothing.
- R7: Pins are only examined on frameTick cycles. A strobe pulse that rises and falls between two ticks shifts no bit, and a strobe held high over several ticks shifts one bit.
- R8: Each register update comes with exactly one cycle of wrPulse, with wrIndex equal to the updated index. The new value is visible in the same cycle.
- R9: Register 2 is decoded as erleThr in bits 15:14, noiseThr in 13:12, hdDetThr in 11:10, holdDelay in 9:8, noiseRamp in 7:6, suppThr in 5:4 and pathSens in bit 3. micEnable is register 0 bit 15.
- R10: Strobe edges beyond the sixteenth in one frame are ignored, so the first sixteen bits form the word.
- R11: If serEnableN falls again during the trailing strobes, the pending word is abandoned and a new frame starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Chip clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameTick | input | 1 | One-cycle pulse at the frame rate; pins are examined only here |
| serStrobe | input | 1 | Serial strobe; rising edges clock bits |
| serEnableN | input | 1 | Active-low frame enable |
| serData | input | 1 | Serial data bit |
| ctrlRegs | output | 64 | All four registers, index i in bits 16*i+15 : 16*i |
| micEnable | output | 1 | Register 0 bit 15 |
| erleThr | output | 2 | Register 2 bits 15:14 |
| noiseThr | output | 2 | Register 2 bits 13:12 |
| hdDetThr | output | 2 | Register 2 bits 11:10 |
| holdDelay | output | 2 | Register 2 bits 9:8 |
| noiseRamp | output | 2 | Register 2 bits 7:6 |
| suppThr | output | 2 | Register 2 bits 5:4 |
| pathSens | output | 1 | Register 2 bit 3 |
| wrPulse | output | 1 | One-cycle pulse when a register is written |
| wrIndex | output | 2 | Index of the register written |

## Verification
The bench looks for early commits. It stops after three trailing strobes, where a port that committed on frame-enable release or on a short count would show a changed register. It sends a strobe glitch between ticks and a strobe held high across ticks, which a port that sampled every clock or counted levels would turn into extra bits and a shifted word. Partial frames, eighteen-bit frames, odd words and a frame restarted during its trailing pulses are also driven. A design that got any of these wrong would write a corrupted word or write to the wrong register, and the scoreboard catches that as an unexpected, missing or mismatched write.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
  parameter int WORD_W   = 16;
  parameter int NUM_REGS = 4;
  parameter int TRAIL_PULSES = 4;
  parameter int MIC_BIT  = 15;

  typedef struct packed {
    logic clear;   // start of a new frame
    logic shift;   // capture one data bit
    logic commit;  // trailing pulses done, write the word
  } ctlStrobes_t;
endpackage

// File: rtl/serctl_sync.sv
module serctl_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= RST_VAL;
    end else begin
      stage[0] <= din;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/serctl_ctrl.sv
module serctl_ctrl
  import serctl_pkg::*;
#(
  parameter int WORD_W = serctl_pkg::WORD_W,
  parameter int TRAIL_PULSES = serctl_pkg::TRAIL_PULSES
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameTick,
  input  logic        strobeS,
  input  logic        enableNS,
  output ctlStrobes_t stb
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam int TRL_W = (TRAIL_PULSES > 1) ? $clog2(TRAIL_PULSES) : 1;
  localparam logic [CNT_W-1:0] BIT_FULL   = CNT_W'(WORD_W);
  localparam logic [TRL_W-1:0] TRAIL_LAST = TRL_W'(TRAIL_PULSES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_TRAIL} state_t;

  state_t state, stateN;
  logic [CNT_W-1:0] bitCnt;
  logic [TRL_W-1:0] trailCnt;
  logic strobePrev;
  logic strobeRise;
  logic trailInc;

  assign strobeRise = frameTick && strobeS && !strobePrev;

  always_comb begin
    stateN   = state;
    stb      = '0;
    trailInc = 1'b0;
    if (frameTick) begin
      case (state)
        ST_IDLE: begin
          if (!enableNS) stateN = ST_SHIFT;
        end
        ST_SHIFT: begin
          if (enableNS) begin
            stateN = (bitCnt == BIT_FULL) ? ST_TRAIL : ST_IDLE;
          end else if (strobeRise && bitCnt != BIT_FULL) begin
            stb.shift = 1'b1;
          end
        end
        ST_TRAIL: begin
          if (!enableNS) begin
            stateN = ST_SHIFT;
          end else if (strobeRise) begin
            if (trailCnt == TRAIL_LAST) begin
              stb.commit = 1'b1;
              stateN = ST_IDLE;
            end else begin
              trailInc = 1'b1;
            end
          end
        end
        default: stateN = ST_IDLE;
      endcase
    end
    stb.clear = (state != ST_SHIFT) && (stateN == ST_SHIFT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      trailCnt   <= '0;
      strobePrev <= 1'b0;
    end else begin
      state <= stateN;
      if (frameTick) strobePrev <= strobeS;
      if (stb.clear) bitCnt <= '0;
      else if (stb.shift) bitCnt <= bitCnt + 1'b1;
      if (state != ST_TRAIL && stateN == ST_TRAIL) trailCnt <= '0;
      else if (trailInc) trailCnt <= trailCnt + 1'b1;
    end
  end

  // R7: pins only act on tick cycles
  p_act_on_tick_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.shift || stb.commit) |-> frameTick);

  // R10: never more than a word of bits counted
  p_bitcnt_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= BIT_FULL);

  // R6: trailing phase only after a full word
  p_trail_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TRAIL && $past(state) == ST_SHIFT) |-> $past(bitCnt) == BIT_FULL);

  // R3: a commit happens only with frame enable released
  p_commit_released_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |-> enableNS);
endmodule

// File: rtl/serctl_dpath.sv
module serctl_dpath
  import serctl_pkg::*;
#(
  parameter int WORD_W   = serctl_pkg::WORD_W,
  parameter int NUM_REGS = serctl_pkg::NUM_REGS,
  parameter int MIC_BIT  = serctl_pkg::MIC_BIT
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctlStrobes_t                stb,
  input  logic                       dataS,
  output logic [NUM_REGS*WORD_W-1:0] regsFlat,
  output logic                       wrPulse,
  output logic [$clog2(NUM_REGS)-1:0] wrIndex
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [WORD_W-1:0] shiftReg;
  logic [IDX_W-1:0]  selIdx;
  logic              wordOk;
  logic [WORD_W-1:0] regs [NUM_REGS];

  assign selIdx = shiftReg[IDX_W:1];
  assign wordOk = !shiftReg[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      wrPulse  <= 1'b0;
      wrIndex  <= '0;
    end else begin
      if (stb.clear) shiftReg <= '0;
      else if (stb.shift) shiftReg <= {shiftReg[WORD_W-2:0], dataS};
      wrPulse <= stb.commit && wordOk;
      if (stb.commit && wordOk) wrIndex <= selIdx;
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [WORD_W-1:0] RST_WORD =
      (WORD_W'(i) << 1) | ((i == 0) ? (WORD_W'(1) << MIC_BIT) : '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regs[i] <= RST_WORD;
      else if (stb.commit && wordOk && selIdx == IDX_W'(i)) regs[i] <= shiftReg;
    end

    assign regsFlat[i*WORD_W +: WORD_W] = regs[i];

    // R4: a register not addressed by a valid commit holds its value
    p_hold_unselected_r4: assert property (@(posedge clk) disable iff (!rstN)
      !(stb.commit && wordOk && selIdx == IDX_W'(i)) |=> $stable(regs[i]));
  end

  // R8: write pulse lasts a single cycle
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrPulse |=> !wrPulse);

  // R5: an odd word produces no write pulse
  p_odd_discard_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && shiftReg[0]) |=> !wrPulse);
endmodule

// File: rtl/serctl_port.sv
module serctl_port
  import serctl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameTick,
  input  logic        serStrobe,
  input  logic        serEnableN,
  input  logic        serData,
  output logic [63:0] ctrlRegs,
  output logic        micEnable,
  output logic [1:0]  erleThr,
  output logic [1:0]  noiseThr,
  output logic [1:0]  hdDetThr,
  output logic [1:0]  holdDelay,
  output logic [1:0]  noiseRamp,
  output logic [1:0]  suppThr,
  output logic        pathSens,
  output logic        wrPulse,
  output logic [1:0]  wrIndex
);
  localparam int W = serctl_pkg::WORD_W;

  logic [2:0]  pinsS;
  ctlStrobes_t stb;
  logic [W-1:0] reg0, reg2;

  serctl_sync #(.W(3), .STAGES(2), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rstN(rstN),
    .din({serStrobe, serEnableN, serData}),
    .dout(pinsS)
  );

  serctl_ctrl #(.WORD_W(W), .TRAIL_PULSES(serctl_pkg::TRAIL_PULSES)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameTick(frameTick),
    .strobeS(pinsS[2]), .enableNS(pinsS[1]), .stb(stb)
  );

  serctl_dpath #(.WORD_W(W), .NUM_REGS(serctl_pkg::NUM_REGS),
                 .MIC_BIT(serctl_pkg::MIC_BIT)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .dataS(pinsS[0]),
    .regsFlat(ctrlRegs), .wrPulse(wrPulse), .wrIndex(wrIndex)
  );

  assign reg0 = ctrlRegs[0*W +: W];
  assign reg2 = ctrlRegs[2*W +: W];

  assign micEnable = reg0[serctl_pkg::MIC_BIT];
  assign erleThr   = reg2[15:14];
  assign noiseThr  = reg2[13:12];
  assign hdDetThr  = reg2[11:10];
  assign holdDelay = reg2[9:8];
  assign noiseRamp = reg2[7:6];
  assign suppThr   = reg2[5:4];
  assign pathSens  = reg2[3];
endmodule

// File: tb/tb_serctl_port.sv
module tb_serctl_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameTick = 1'b0;
  logic serStrobe = 1'b0;
  logic serEnableN = 1'b1;
  logic serData = 1'b0;
  logic [63:0] ctrlRegs;
  logic micEnable, pathSens, wrPulse;
  logic [1:0] erleThr, noiseThr, hdDetThr, holdDelay, noiseRamp, suppThr, wrIndex;

  int nChecks = 0;
  int nFails = 0;

  typedef struct { int idx; logic [15:0] word; } exp_t;
  exp_t sbQ[$];
  logic [15:0] model [4];
  logic prevPulse = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serctl_port dut (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .serStrobe(serStrobe),
    .serEnableN(serEnableN), .serData(serData), .ctrlRegs(ctrlRegs),
    .micEnable(micEnable), .erleThr(erleThr), .noiseThr(noiseThr),
    .hdDetThr(hdDetThr), .holdDelay(holdDelay), .noiseRamp(noiseRamp),
    .suppThr(suppThr), .pathSens(pathSens), .wrPulse(wrPulse), .wrIndex(wrIndex)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pops on every write pulse
  always @(negedge clk) begin
    if (rstN) begin
      if (prevPulse) chk(!wrPulse, "R8 pulse width", 64'(wrPulse), 64'd0);
      if (wrPulse) begin
        if (sbQ.size() == 0) begin
          chk(1'b0, "R3/R5/R6 unexpected write", 64'(wrIndex), 64'hFFFF);
        end else begin
          exp_t e;
          e = sbQ.pop_front();
          chk(wrIndex == 2'(e.idx), "R8 wrIndex", 64'(wrIndex), 64'(e.idx));
          model[e.idx] = e.word;
          chk(ctrlRegs == {model[3], model[2], model[1], model[0]}, "R4 register bank on write",
              ctrlRegs, {model[3], model[2], model[1], model[0]});
        end
      end
      prevPulse = wrPulse;
    end
  end

  task automatic step(input logic s, input logic en, input logic d);
    @(negedge clk);
    serStrobe = s; serEnableN = en; serData = d;
    repeat (3) @(negedge clk);
    frameTick = 1'b1;
    @(negedge clk);
    frameTick = 1'b0;
  endtask

  task automatic sendBits(input logic [31:0] pat, input int n);
    step(1'b0, 1'b0, 1'b0);
    for (int b = n - 1; b >= 0; b--) begin
      step(1'b0, 1'b0, pat[b]);
      step(1'b1, 1'b0, pat[b]);
    end
    step(1'b0, 1'b1, 1'b0);
  endtask

  task automatic trail(input int n);
    for (int k = 0; k < n; k++) begin
      step(1'b1, 1'b1, 1'b0);
      step(1'b0, 1'b1, 1'b0);
    end
  endtask

  task automatic expectWrite(input logic [15:0] w);
    exp_t e;
    e.idx = int'(w[2:1]);
    e.word = w;
    sbQ.push_back(e);
  endtask

  task automatic checkAll(input string req);
    repeat (3) @(negedge clk);
    chk(sbQ.size() == 0, {req, " pending write missing"}, 64'(sbQ.size()), 64'd0);
    sbQ.delete();
    chk(ctrlRegs == {model[3], model[2], model[1], model[0]}, req,
        ctrlRegs, {model[3], model[2], model[1], model[0]});
  endtask

  task automatic fullWrite(input logic [15:0] w, input string req);
    sendBits({16'h0, w}, 16);
    trail(3);
    expectWrite(w);
    trail(1);
    checkAll(req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    model[0] = 16'h8000; model[1] = 16'h0002; model[2] = 16'h0004; model[3] = 16'h0006;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(ctrlRegs == 64'h0006_0004_0002_8000, "R1 reset words", ctrlRegs, 64'h0006_0004_0002_8000);
    chk(micEnable == 1'b1, "R1 mic enable", 64'(micEnable), 64'd1);
    chk({erleThr, noiseThr, hdDetThr, holdDelay, noiseRamp, suppThr, pathSens} == 13'd0,
        "R1 reg2 fields", 64'({erleThr, noiseThr, hdDetThr, holdDelay, noiseRamp, suppThr, pathSens}), 64'd0);
    chk(wrPulse == 1'b0, "R1 wrPulse idle", 64'(wrPulse), 64'd0);

    // R2 R9 R4: write register 2 with distinct field values
    fullWrite(16'h9C6C, "R2 R4 reg2 write");
    chk({erleThr, noiseThr, hdDetThr, holdDelay, noiseRamp, suppThr, pathSens} ==
        {2'd2, 2'd1, 2'd3, 2'd0, 2'd1, 2'd2, 1'b1}, "R9 reg2 fields",
        64'({erleThr, noiseThr, hdDetThr, holdDelay, noiseRamp, suppThr, pathSens}),
        64'({2'd2, 2'd1, 2'd3, 2'd0, 2'd1, 2'd2, 1'b1}));

    // R9: clear mic enable through register 0
    fullWrite(16'h0000, "R4 reg0 write");
    chk(micEnable == 1'b0, "R9 mic enable cleared", 64'(micEnable), 64'd0);
    fullWrite(16'h1232, "R4 reg1 write");
    fullWrite(16'hFFFE, "R4 reg3 write");

    // R5: odd word discarded
    sendBits({16'h0, 16'h5557}, 16);
    trail(4);
    checkAll("R5 odd word discarded");

    // R6: partial frame dropped
    sendBits({22'h0, 10'h3FE}, 10);
    trail(4);
    checkAll("R6 partial frame dropped");

    // R3: three trailing pulses are not enough
    sendBits({16'h0, 16'hA5A2}, 16);
    trail(3);
    checkAll("R3 no write after three pulses");
    expectWrite(16'hA5A2);
    trail(1);
    checkAll("R3 write on fourth pulse");

    // R7: glitch between ticks ignored, held strobe counts once
    step(1'b0, 1'b0, 1'b0);
    for (int b = 15; b >= 0; b--) begin
      logic [15:0] w;
      w = 16'h3C04;
      step(1'b0, 1'b0, w[b]);
      if (b == 9) begin
        @(negedge clk); serStrobe = 1'b1;
        @(negedge clk); serStrobe = 1'b0;
      end
      step(1'b1, 1'b0, w[b]);
      if (b == 5) begin
        step(1'b1, 1'b0, w[b]);
        step(1'b1, 1'b0, w[b]);
      end
    end
    step(1'b0, 1'b1, 1'b0);
    trail(3);
    expectWrite(16'h3C04);
    trail(1);
    checkAll("R7 tick sampling");

    // R10: eighteen bits sent, first sixteen form the word
    sendBits({14'h0, 16'h7E70, 2'b11}, 18);
    trail(3);
    expectWrite(16'h7E70);
    trail(1);
    checkAll("R10 extra strobes ignored");

    // R11: frame enable drops during trailing pulses
    sendBits({16'h0, 16'h1112}, 16);
    trail(2);
    sendBits({16'h0, 16'h4446}, 16);
    trail(3);
    expectWrite(16'h4446);
    trail(1);
    checkAll("R11 trailing abort");

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule